// File: doc/BRIEF.md
# Paired Mailbox Doorbell Interrupt Unit

This block sits in the receive side of a board's bus interface. It holds a bank of eight 32-bit mailbox registers grouped into four receive windows. For window `w`, the register at index `w` holds the start address of a message that a remote sender has already placed in local memory. The register at index `w + 4` holds that message's length. Remote senders load the registers through a plain indexed write port. A window signals the local processor only when both of its values have arrived, whatever the order in which they came.

The local processor reads the stored values back through a registered read port. It watches a status vector that carries per-window pending and overrun flags, and it releases a window with a per-window acknowledge. Each window's interrupt is its pending flag gated by an enable mask. A single combined line is the OR of those gated interrupts. Up to four messages can wait at once, one per window. A sender that writes again into a window the processor has not yet released is flagged as an overrun, and the write does not corrupt the stored pair.

Top module: `mbox_doorbell_unit`

## Requirements
- R1: After a synchronous reset, `status` is all zero, `irq_win` and `irq` are low, `rd_data` is zero, and all four enable bits are 1.
- R2: A write to index 0–7 whose window is not pending stores `wr_data`. Setting `rd_idx` to that index returns the value in `rd_data` on the following clock edge. Index `k` belongs to window `k mod 4`: indices 0–3 are addresses and 4–7 are lengths.
- R3: The pending bit of window `w` (`status[w]`) sets on the edge of the write that completes the pair, with the address and length written in either order. A lone address or a lone length never sets it.
- R4: Rewriting the same half of a window before the pair is complete overwrites the stored value and does not set pending.
- R5: A write to either half of a pending window sets that window's overrun bit (`status[4+w]`) and leaves the stored value unchanged.
- R6: `ack[w]` clears window `w`'s pending bit, its overrun bit and both of its written flags on the next edge. After that, a single half write does not raise pending again.
- R7: `irq_win[w]` equals pending AND enable for window `w`, and it changes on the same edge as `status`. `irq` is the OR of `irq_win`.
- R8: With enable bit `w` cleared, window `w` can be pending while `irq_win[w]` stays low. Setting the bit again (`en_we` with `en_din`) raises `irq_win[w]` on that edge.
- R9: Writes to indices 8–15 change no stored value and no flag. Reads of indices 8–15 return zero.
- R10: The four windows are independent: all four can be pending at the same time, and acknowledging one leaves the others untouched.
- R11: When `ack[w]` and a write to window `w` fall in the same cycle, the acknowledge clears every flag of `w`. The written value is stored only if `w` was not pending before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Mailbox write strobe |
| wr_idx | input | 4 | Mailbox index of the write |
| wr_data | input | 32 | Write value |
| ack | input | 4 | Per-window acknowledge, one bit per window |
| en_we | input | 1 | Load the enable mask |
| en_din | input | 4 | New enable mask |
| rd_idx | input | 4 | Mailbox index to read |
| rd_data | output | 32 | Registered read value |
| status | output | 8 | [3:0] pending per window, [7:4] overrun per window |
| irq_win | output | 4 | Per-window gated interrupt |
| irq | output | 1 | Combined interrupt |

## Verification
The main sequence fills windows with the address first in some cases and the length first in others. This separates the pair-completion rule from a rule that fires on one particular half. Repeated writes to the same half show that pending needs both halves and not just two writes. Writes into pending windows, writes to out-of-range indices, and an acknowledge that lands in the same cycle as a write show apart three cases: a dropped write, a stored write, and a write that raises an overrun. Masking and a mid-run reset check that the gating and reset values act on the interrupt lines separately from the status flags.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Per-window bookkeeping kept by each window slice.
  typedef struct packed {
    logic addr_seen;
    logic len_seen;
    logic pending;
    logic overrun;
  } win_state_t;

  localparam win_state_t WIN_IDLE = '{addr_seen: 1'b0, len_seen: 1'b0,
                                      pending: 1'b0, overrun: 1'b0};

endpackage

// File: rtl/mbox_regfile.sv
module mbox_regfile #(
  parameter int DW    = 32,
  parameter int NMBOX = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [DW-1:0]    wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [DW-1:0]    rdata
);
  localparam int MW = $clog2(NMBOX);

  logic [DW-1:0] mem [NMBOX];
  logic          rd_in_range;

  assign rd_in_range = (raddr < IDX_W'(NMBOX));

  // Write port without reset so that the array can map to RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr[MW-1:0]] <= wdata;
  end

  // Registered read, zero for indices outside the bank.
  always_ff @(posedge clk) begin
    if (rst)              rdata <= '0;
    else if (rd_in_range) rdata <= mem[raddr[MW-1:0]];
    else                  rdata <= '0;
  end

  logic unused_waddr_hi;
  assign unused_waddr_hi = ^waddr[IDX_W-1:MW];

endmodule

// File: rtl/mbox_window.sv
module mbox_window
  import mbox_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit_addr,
  input  logic hit_len,
  input  logic ack,
  output logic accept,
  output logic pending_q,
  output logic pending_nxt,
  output logic overrun_q
);
  win_state_t st_q, st_d;

  // A write is stored only while the window is still collecting its pair.
  assign accept = (hit_addr | hit_len) & ~st_q.pending;

  always_comb begin
    st_d = st_q;
    if (ack) begin
      st_d = WIN_IDLE;
    end else if (st_q.pending) begin
      if (hit_addr | hit_len) st_d.overrun = 1'b1;
    end else begin
      st_d.addr_seen = st_q.addr_seen | hit_addr;
      st_d.len_seen  = st_q.len_seen  | hit_len;
      st_d.pending   = st_d.addr_seen & st_d.len_seen;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= WIN_IDLE;
    else     st_q <= st_d;
  end

  assign pending_q   = st_q.pending;
  assign pending_nxt = st_d.pending;
  assign overrun_q   = st_q.overrun;

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq #(
  parameter int NWIN = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NWIN-1:0] pend_nxt,
  input  logic            en_we,
  input  logic [NWIN-1:0] en_din,
  output logic [NWIN-1:0] irq_win,
  output logic            irq
);
  logic [NWIN-1:0] en_q, en_nxt, gated_nxt;

  assign en_nxt    = en_we ? en_din : en_q;
  assign gated_nxt = pend_nxt & en_nxt;

  // Interrupts are registered from next-state so that they move with status.
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '1;
      irq_win <= '0;
      irq     <= 1'b0;
    end else begin
      en_q    <= en_nxt;
      irq_win <= gated_nxt;
      irq     <= |gated_nxt;
    end
  end

endmodule

// File: rtl/mbox_doorbell_unit.sv
module mbox_doorbell_unit #(
  parameter int DW    = 32,
  parameter int NWIN  = 4,
  parameter int IDX_W = 4   // must exceed $clog2(2*NWIN) so out-of-range indices exist
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic [NWIN-1:0]   ack,
  input  logic              en_we,
  input  logic [NWIN-1:0]   en_din,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DW-1:0]     rd_data,
  output logic [2*NWIN-1:0] status,
  output logic [NWIN-1:0]   irq_win,
  output logic              irq
);
  localparam int NMBOX = 2 * NWIN;
  localparam int MW    = $clog2(NMBOX);

  logic            wr_in_range;
  logic [NWIN-1:0] hit_addr, hit_len, accept, pend_q, pend_nxt, ovr_q;
  logic            store_en;

  assign wr_in_range = wr_en && (wr_idx < IDX_W'(NMBOX));

  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_win
      assign hit_addr[w] = wr_in_range && (wr_idx[MW-1:0] == MW'(w));
      assign hit_len[w]  = wr_in_range && (wr_idx[MW-1:0] == MW'(w + NWIN));

      mbox_window u_win (
        .clk         (clk),
        .rst         (rst),
        .hit_addr    (hit_addr[w]),
        .hit_len     (hit_len[w]),
        .ack         (ack[w]),
        .accept      (accept[w]),
        .pending_q   (pend_q[w]),
        .pending_nxt (pend_nxt[w]),
        .overrun_q   (ovr_q[w])
      );
    end
  endgenerate

  assign store_en = |accept;

  mbox_regfile #(.DW(DW), .NMBOX(NMBOX), .IDX_W(IDX_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (store_en),
    .waddr (wr_idx),
    .wdata (wr_data),
    .raddr (rd_idx),
    .rdata (rd_data)
  );

  mbox_irq #(.NWIN(NWIN)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .pend_nxt (pend_nxt),
    .en_we    (en_we),
    .en_din   (en_din),
    .irq_win  (irq_win),
    .irq      (irq)
  );

  assign status = {ovr_q, pend_q};

endmodule

// File: rtl/mbox_doorbell_chk.sv
module mbox_doorbell_chk #(
  parameter int NWIN  = 4,
  parameter int IDX_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [NWIN-1:0]   ack,
  input logic              en_we,
  input logic [2*NWIN-1:0] status,
  input logic [NWIN-1:0]   irq_win,
  input logic              irq
);
  localparam int NMBOX = 2 * NWIN;

  generate
    for (genvar w = 0; w < NWIN; w++) begin : g_w
      // R3: pending can only rise on the edge of a write
      a_r3_pend_needs_write: assert property (@(posedge clk) disable iff (rst)
        $rose(status[w]) |-> $past(wr_en));

      // R6: acknowledge leaves the window clean
      a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
        ack[w] |=> (!status[w] && !status[NWIN+w]));

      // R5: a write into a pending window flags overrun
      a_r5_overrun_flag: assert property (@(posedge clk) disable iff (rst)
        (status[w] && wr_en && (wr_idx == IDX_W'(w)) && !ack[w]) |=> status[NWIN+w]);

      // R7: a window interrupt implies the window is pending
      a_r7_irq_needs_pend: assert property (@(posedge clk) disable iff (rst)
        irq_win[w] |-> status[w]);
    end
  endgenerate

  // R9: out-of-range writes leave every flag alone
  a_r9_oor_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx >= IDX_W'(NMBOX)) && (ack == '0) && !en_we) |=> $stable(status));

  // R7: combined line only while some window is pending
  a_r7_comb_needs_pend: assert property (@(posedge clk) disable iff (rst)
    irq |-> (status[NWIN-1:0] != '0));

endmodule

bind mbox_doorbell_unit mbox_doorbell_chk #(.NWIN(NWIN), .IDX_W(IDX_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_idx  (wr_idx),
  .ack     (ack),
  .en_we   (en_we),
  .status  (status),
  .irq_win (irq_win),
  .irq     (irq)
);

// File: tb/test_mbox_doorbell_unit.sv
module test_mbox_doorbell_unit;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [31:0] wr_data;
  logic [3:0]  ack;
  logic        en_we;
  logic [3:0]  en_din;
  logic [3:0]  rd_idx;
  logic [31:0] rd_data;
  logic [7:0]  status;
  logic [3:0]  irq_win;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mbox_doorbell_unit i_mbox_doorbell_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .ack(ack), .en_we(en_we), .en_din(en_din), .rd_idx(rd_idx),
    .rd_data(rd_data), .status(status), .irq_win(irq_win), .irq(irq)
  );

  // {we, idx[3:0], data_lo[15:0], ack[3:0], exp_status[7:0], exp_irq_win[3:0]}
  localparam int NV = 13;
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 4'd0, 16'h0001, 4'h0, 8'h00, 4'h0}, // R3 lone address
    {1'b1, 4'd4, 16'h0002, 4'h0, 8'h01, 4'h1}, // R3 pair done
    {1'b1, 4'd5, 16'h0003, 4'h0, 8'h01, 4'h1}, // R3 length first
    {1'b1, 4'd1, 16'h0004, 4'h0, 8'h03, 4'h3}, // R3 either order
    {1'b1, 4'd0, 16'h0005, 4'h0, 8'h13, 4'h3}, // R5 overrun
    {1'b1, 4'd9, 16'h0006, 4'h0, 8'h13, 4'h3}, // R9 out of range
    {1'b0, 4'd0, 16'h0000, 4'h1, 8'h02, 4'h2}, // R6 ack window 0, R10 others kept
    {1'b1, 4'd6, 16'h0008, 4'h0, 8'h02, 4'h2}, // R3
    {1'b1, 4'd2, 16'h0009, 4'h0, 8'h06, 4'h6}, // R10
    {1'b1, 4'd3, 16'h000A, 4'h8, 8'h06, 4'h6}, // R11 ack with write
    {1'b1, 4'd7, 16'h000B, 4'h0, 8'h06, 4'h6}, // R11 address flag was cleared
    {1'b1, 4'd3, 16'h000C, 4'h0, 8'h0E, 4'hE}, // R10 three pending
    {1'b0, 4'd0, 16'h0000, 4'hE, 8'h00, 4'h0}  // R6 multi ack
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 1'b0; wr_idx = '0; wr_data = '0; ack = '0; en_we = 1'b0; en_din = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk); idle(); wr_en = 1'b1; wr_idx = idx; wr_data = d;
    tick();
    @(negedge clk); idle();
  endtask

  task automatic do_ack(input logic [3:0] m);
    @(negedge clk); idle(); ack = m;
    tick();
    @(negedge clk); idle();
  endtask

  task automatic set_en(input logic [3:0] m);
    @(negedge clk); idle(); en_we = 1'b1; en_din = m;
    tick();
    @(negedge clk); idle();
  endtask

  task automatic rd(input string req, input logic [3:0] idx, input logic [31:0] exp);
    @(negedge clk); rd_idx = idx;
    tick();
    chk(req, rd_data, exp);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle(); rd_idx = '0; rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1 reset values
    chk("R1 status", 32'(status), 32'h0);
    chk("R1 irq_win", 32'(irq_win), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 rd_data", rd_data, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle();
      wr_en   = VEC[i][36];
      wr_idx  = VEC[i][35:32];
      wr_data = {16'hD00D, VEC[i][31:16]};
      ack     = VEC[i][15:12];
      tick();
      chk($sformatf("R3/R5/R6/R10/R11 status step %0d", i), 32'(status), 32'(VEC[i][11:4]));
      chk($sformatf("R7 irq_win step %0d", i), 32'(irq_win), 32'(VEC[i][3:0]));
      chk($sformatf("R7 irq step %0d", i), 32'(irq), 32'(|VEC[i][3:0]));
    end
    @(negedge clk); idle();

    // R2 readback, R5 kept value, R11 stored-then-overwritten, R9 zero read
    rd("R2 idx0", 4'd0, 32'hD00D0001);
    rd("R2 idx4", 4'd4, 32'hD00D0002);
    rd("R2 idx1", 4'd1, 32'hD00D0004);
    rd("R2 idx2", 4'd2, 32'hD00D0009);
    rd("R11 idx3", 4'd3, 32'hD00D000C);
    rd("R9 idx9", 4'd9, 32'h0);

    // R4 rewrite same half
    wr(4'd2, 32'hD00D0020);
    wr(4'd2, 32'hD00D0021);
    chk("R4 no pending", 32'(status), 32'h0);
    rd("R4 overwrite", 4'd2, 32'hD00D0021);
    wr(4'd6, 32'hD00D0022);
    chk("R4 pair", 32'(status), 32'h04);
    do_ack(4'h4);

    // R8 masking
    set_en(4'hE);
    wr(4'd0, 32'h1);
    wr(4'd4, 32'h2);
    chk("R8 masked pending", 32'(status), 32'h01);
    chk("R8 masked irq_win", 32'(irq_win), 32'h0);
    chk("R8 masked irq", 32'(irq), 32'h0);
    set_en(4'hF);
    chk("R8 unmask irq_win", 32'(irq_win), 32'h1);
    chk("R8 unmask irq", 32'(irq), 32'h1);

    // R1 reset mid-run restores enables
    set_en(4'h0);
    @(negedge clk); rst = 1'b1;
    tick();
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 status after reset", 32'(status), 32'h0);
    chk("R1 irq after reset", 32'(irq), 32'h0);
    wr(4'd1, 32'h3);
    wr(4'd5, 32'h4);
    chk("R1 enables back to ones", 32'(irq_win), 32'h2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule